// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Selectable Refresh

This block turns single read and write requests from a host into strobe sequences for a classic asynchronous DRAM. The DRAM has multiplexed address pins and four active-low strobes: row strobe, column strobe, write enable and output enable. The host side is a valid/ready port that carries a combined row and column address. Read data comes back with a one-cycle valid pulse. The memory data bus is split into an output, an output-enable and an input, so that the pad ring can build the bidirectional pins.

The controller also refreshes the memory on its own. A timer spreads refresh operations evenly over the refresh interval, and the `ref_cbr` input chooses the method. In row-strobe-only refresh, the controller puts its own row counter on the address pins and pulses the row strobe. In column-before-row refresh, the memory uses its internal counter. Every strobe window is a whole number of controller clocks set by a parameter. A pending refresh always wins over a waiting request, but it never interrupts an access that has already started.

Top module: `adram_ctrl`

## Requirements
- R1: After reset, all four strobes are high, `dram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: For an access, the row (request address bits [ROW_W+COL_W-1:COL_W]) is on `dram_addr` when the row strobe falls. The column (bits [COL_W-1:0]) is on `dram_addr` when the column strobe falls.
- R3: A write holds write enable low with `dram_dq_oe`=1 and the data on `dram_dq_out` at the column strobe fall. A read holds write enable high, and the word read appears on `rd_data` with a one-cycle `rd_valid` pulse.
- R4: `dram_dq_oe` is never 1 while both strobes are low, write enable is high and output enable is low.
- R5: The column strobe falls only after the row strobe has been low for at least T_RCD clocks.
- R6: Every row strobe low pulse lasts at least T_RAS clocks.
- R7: The row strobe stays high for at least T_RP clocks before each fall.
- R8: With `ref_cbr`=0, a refresh puts the internal row counter on `dram_addr`, pulses the row strobe while the column strobe stays high, and then adds 1 to the counter, wrapping at 2^ROW_W.
- R9: With `ref_cbr`=1, a refresh drives the column strobe low at least one clock before the row strobe falls, and leaves the internal row counter unchanged.
- R10: With no host traffic, refresh operations start exactly REF_TOTAL/2^ROW_W clocks apart.
- R11: While a refresh is pending, `req_ready` is 0, and the refresh runs before a request that is already waiting.
- R12: `req_ready` falls in the cycle after a request is accepted and returns only after the precharge window has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_cbr | input | 1 | Refresh method: 1 column-before-row, 0 row-strobe-only |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the memory |
| dram_dq_oe | output | 1 | Enable for the controller data driver |
| dram_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench runs writes and reads of all-zero, all-one and alternating data patterns to corner rows and columns, including the top row and top column. These show whether row and column are multiplexed in the right order and whether the read path returns the right word. Idle periods with each refresh method tell apart a row-strobe-only pulse, which advances the row counter and has the column strobe high, from a column-first pulse, which leaves the counter unchanged. A request placed in the same cycle that a refresh becomes pending checks that refresh wins arbitration without being deferred.

// File: rtl/adram_pkg.sv
package adram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW_SETUP,
    ST_ROW_OPEN,
    ST_COL_SETUP,
    ST_COL_STROBE,
    ST_ROW_HOLD,
    ST_REF_SETUP,
    ST_CBR_LEAD,
    ST_REF_OPEN,
    ST_PRECHARGE
  } adram_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adram_refresh_timer.sv
module adram_refresh_timer #(
  parameter int unsigned REF_PER = 400,
  parameter int unsigned ROW_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack,
  input  logic             row_adv,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);

  localparam int unsigned TW = (REF_PER > 1) ? $clog2(REF_PER) : 1;

  logic [TW-1:0]    tick_q, tick_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             wrap;

  assign wrap = (tick_q == TW'(REF_PER - 1));

  always_comb begin
    tick_d = wrap ? '0 : tick_q + 1'b1;
    pend_d = pend_q;
    if (ref_ack) pend_d = 1'b0;
    if (wrap)    pend_d = 1'b1;
    row_d  = row_q;
    if (row_adv) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tick_q <= tick_d;
      pend_q <= pend_d;
      if (row_adv) row_q <= row_d;
    end
  end

  assign ref_pend = pend_q;
  assign ref_row  = row_q;

endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_CAS = 2,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         ref_pend,
  input  logic         ref_cbr,
  input  logic         is_write,
  output logic         req_ready,
  output logic         accept,
  output logic         ref_ack,
  output logic         row_adv,
  output logic         cap_en,
  output logic         cbr_q,
  output adram_state_e state,
  output logic         ras_n,
  output logic         cas_n,
  output logic         we_n,
  output logic         oe_n,
  output logic         dq_oe
);

  localparam int unsigned T_ACC  = T_RCD + 1 + T_CAS;
  localparam int unsigned T_TAIL = (T_RAS > T_ACC) ? (T_RAS - T_ACC) : 1;
  localparam int unsigned T_MAX  = umax(umax(T_RCD, T_CAS), umax(umax(T_RAS, T_RP), T_TAIL));
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

  adram_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cbr_d, cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    cbr_d   = cbr_q;
    accept  = 1'b0;
    ref_ack = 1'b0;
    row_adv = 1'b0;
    cap_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          ref_ack = 1'b1;
          cbr_d   = ref_cbr;
          st_d    = ref_cbr ? ST_CBR_LEAD : ST_REF_SETUP;
        end else if (req_valid) begin
          accept = 1'b1;
          st_d   = ST_ROW_SETUP;
        end
      end
      ST_ROW_SETUP: begin
        st_d  = ST_ROW_OPEN;
        cnt_d = CNT_W'(T_RCD - 1);
      end
      ST_ROW_OPEN: if (cnt_zero) st_d = ST_COL_SETUP;
      ST_COL_SETUP: begin
        st_d  = ST_COL_STROBE;
        cnt_d = CNT_W'(T_CAS - 1);
      end
      ST_COL_STROBE: if (cnt_zero) begin
        cap_en = !is_write;
        st_d   = ST_ROW_HOLD;
        cnt_d  = CNT_W'(T_TAIL - 1);
      end
      ST_ROW_HOLD: if (cnt_zero) begin
        st_d  = ST_PRECHARGE;
        cnt_d = CNT_W'(T_RP - 1);
      end
      ST_REF_SETUP, ST_CBR_LEAD: begin
        st_d  = ST_REF_OPEN;
        cnt_d = CNT_W'(T_RAS - 1);
      end
      ST_REF_OPEN: if (cnt_zero) begin
        row_adv = !cbr_q;
        st_d    = ST_PRECHARGE;
        cnt_d   = CNT_W'(T_RP - 1);
      end
      ST_PRECHARGE: if (cnt_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cbr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (ref_ack) cbr_q <= cbr_d;
    end
  end

  logic col_phase;
  assign col_phase = (st_q == ST_COL_SETUP) || (st_q == ST_COL_STROBE);

  assign state     = st_q;
  assign req_ready = (st_q == ST_IDLE) && !ref_pend;
  assign ras_n     = !((st_q == ST_ROW_OPEN) || (st_q == ST_COL_SETUP) ||
                       (st_q == ST_COL_STROBE) || (st_q == ST_ROW_HOLD) ||
                       (st_q == ST_REF_OPEN));
  assign cas_n     = !((st_q == ST_COL_STROBE) || (st_q == ST_CBR_LEAD) ||
                       ((st_q == ST_REF_OPEN) && cbr_q));
  assign we_n      = !(is_write && col_phase);
  assign oe_n      = !(!is_write && col_phase);
  assign dq_oe     = is_write && col_phase;

endmodule

// File: rtl/adram_datapath.sv
module adram_datapath
  import adram_pkg::*;
#(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  adram_state_e           state,
  input  logic                   cbr_q,
  input  logic [ROW_W-1:0]       ref_row,
  input  logic                   cap_en,
  input  logic [DATA_W-1:0]      dq_in,
  output logic                   is_write,
  output logic [AW-1:0]          dram_addr,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data
);

  logic [ROW_W+COL_W-1:0] addr_q;
  logic                   wr_q;
  logic [DATA_W-1:0]      wdata_q;
  logic [DATA_W-1:0]      rdata_q;
  logic                   rvld_q;
  logic [ROW_W-1:0]       row_f;
  logic [COL_W-1:0]       col_f;

  assign row_f = addr_q[ROW_W+COL_W-1:COL_W];
  assign col_f = addr_q[COL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (cap_en) rdata_q <= dq_in;
      rvld_q <= cap_en;
    end
  end

  always_comb begin
    unique case (state)
      ST_ROW_SETUP, ST_ROW_OPEN:                dram_addr = AW'(row_f);
      ST_COL_SETUP, ST_COL_STROBE, ST_ROW_HOLD: dram_addr = AW'(col_f);
      ST_REF_SETUP, ST_REF_OPEN:                dram_addr = cbr_q ? '0 : AW'(ref_row);
      default:                                  dram_addr = '0;
    endcase
  end

  assign is_write = wr_q;
  assign dq_out   = wdata_q;
  assign rd_valid = rvld_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl
  import adram_pkg::*;
#(
  parameter int unsigned ROW_W     = 6,
  parameter int unsigned COL_W     = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_CAS     = 2,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned REF_TOTAL = 25600
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       ref_cbr,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic                                       req_write,
  input  logic [ROW_W+COL_W-1:0]                     req_addr,
  input  logic [DATA_W-1:0]                          req_wdata,
  output logic                                       rd_valid,
  output logic [DATA_W-1:0]                          rd_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                       dram_ras_n,
  output logic                                       dram_cas_n,
  output logic                                       dram_we_n,
  output logic                                       dram_oe_n,
  output logic [DATA_W-1:0]                          dram_dq_out,
  output logic                                       dram_dq_oe,
  input  logic [DATA_W-1:0]                          dram_dq_in
);

  localparam int unsigned AW      = umax(ROW_W, COL_W);
  localparam int unsigned NROWS   = 2 ** ROW_W;
  localparam int unsigned REF_PER = (REF_TOTAL / NROWS > 0) ? REF_TOTAL / NROWS : 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             ref_pend, ref_ack, row_adv, accept, cap_en, cbr_q, is_write;
  logic [ROW_W-1:0] ref_row;
  adram_state_e     state;

  adram_refresh_timer #(.REF_PER(REF_PER), .ROW_W(ROW_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ref_ack  (ref_ack),
    .row_adv  (row_adv),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  adram_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .ref_pend  (ref_pend),
    .ref_cbr   (ref_cbr),
    .is_write  (is_write),
    .req_ready (req_ready),
    .accept    (accept),
    .ref_ack   (ref_ack),
    .row_adv   (row_adv),
    .cap_en    (cap_en),
    .cbr_q     (cbr_q),
    .state     (state),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_oe     (dram_dq_oe)
  );

  adram_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .AW(AW)) dp_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (state),
    .cbr_q     (cbr_q),
    .ref_row   (ref_row),
    .cap_en    (cap_en),
    .dq_in     (dram_dq_in),
    .is_write  (is_write),
    .dram_addr (dram_addr),
    .dq_out    (dram_dq_out),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/adram_ctrl_chk.sv
module adram_ctrl_chk #(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_RAS = 6,
  parameter int unsigned T_RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_valid,
  input logic req_ready
);

  localparam int unsigned CMAX = ((T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                                 : ((T_RP > T_RCD) ? T_RP : T_RCD)) + 1;
  localparam int unsigned CW = $clog2(CMAX + 1);

  logic [CW-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= CW'(CMAX);
    end else begin
      lo_q <= ras_n ? '0 : ((lo_q == CW'(CMAX)) ? lo_q : lo_q + 1'b1);
      hi_q <= !ras_n ? '0 : ((hi_q == CW'(CMAX)) ? hi_q : hi_q + 1'b1);
    end
  end

  a_r4_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !cas_n && we_n && !oe_n) |-> !dq_oe);

  a_r5_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (lo_q >= CW'(T_RCD)));

  a_r6_ras_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_q >= CW'(T_RAS)));

  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_q >= CW'(T_RP)));

  a_r9_col_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  a_r3_we_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !ras_n && $past(!cas_n && !ras_n)) |-> $stable(we_n));

  a_r12_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind adram_ctrl adram_ctrl_chk #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .dq_oe     (dram_dq_oe),
  .req_valid (req_valid),
  .req_ready (req_ready)
);

// File: tb/adram_ctrl_tb.sv
`timescale 1ns/1ps
module adram_ctrl_tb_top;

  localparam int ROW_W = 6, COL_W = 5, DATA_W = 8;
  localparam int T_RCD = 2, T_RAS = 6, T_RP = 3;
  localparam int REF_PER = 25600 / 64;

  logic clk = 0, rst_n = 0;
  logic ref_cbr = 0, req_valid = 0, req_write = 0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out, dq_in;
  logic [5:0] addr;

  always #4 clk = ~clk;

  adram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ref_cbr(ref_cbr), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_addr(addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_oe_n(oe_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model and strobe monitor
  logic [DATA_W-1:0] mem [0:2047];
  logic [ROW_W-1:0] cur_row = '0, fall_row = '0, last_ror_row = '0, prev_ror_row = '0;
  logic [COL_W-1:0] cur_col = '0;
  logic ras_prev = 1, cas_prev = 1, ror_cand = 0;
  int lo_cnt = 0, hi_cnt = 1000, fall_t = 0;
  int rcd_err = 0, ras_err = 0, rp_err = 0, bus_err = 0;
  int ror_cnt = 0, cbr_cnt = 0, ref_cnt = 0, ref_t_last = 0, ref_t_prev = 0;
  int cbr_order_err = 0;

  assign dq_in = (!ras_n && !cas_n && we_n && !oe_n) ? mem[{cur_row, cur_col}] : '0;

  initial for (int i = 0; i < 2048; i++) mem[i] = '0;

  always @(negedge clk) if (rst_n) begin
    if (cas_prev && !cas_n && !ras_n) begin
      if (lo_cnt < T_RCD) rcd_err++;
      cur_col = addr[COL_W-1:0];
      ror_cand = 0;
      if (!we_n) begin
        if (!dq_oe) bus_err++;
        mem[{cur_row, cur_col}] = dq_out;
      end
    end
    if (ras_prev && !ras_n) begin
      if (hi_cnt < T_RP) rp_err++;
      if (!cas_n) begin
        if (cas_prev) cbr_order_err++;
        cbr_cnt++; ref_cnt++; ref_t_prev = ref_t_last; ref_t_last = cyc;
      end else begin
        ror_cand = 1; fall_t = cyc; fall_row = addr[ROW_W-1:0]; cur_row = addr[ROW_W-1:0];
      end
      lo_cnt = 0;
    end
    if (!ras_prev && ras_n) begin
      if (lo_cnt < T_RAS) ras_err++;
      if (ror_cand) begin
        ror_cnt++; ref_cnt++;
        prev_ror_row = last_ror_row; last_ror_row = fall_row;
        ref_t_prev = ref_t_last; ref_t_last = fall_t;
        ror_cand = 0;
      end
      hi_cnt = 0;
    end
    if (!ras_n) lo_cnt++; else hi_cnt++;
    if (!ras_n && !cas_n && we_n && !oe_n && dq_oe) bus_err++;
    ras_prev = ras_n; cas_prev = cas_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    while (!req_ready) tick();
  endtask

  task automatic access(input bit wr, input int row, input int col,
                        input logic [7:0] wd, output logic [7:0] rd);
    req_write = wr; req_addr = (ROW_W+COL_W)'((row << COL_W) | col); req_wdata = wd;
    req_valid = 1;
    while (!req_ready) tick();
    tick();
    req_valid = 0;
    chk(req_ready == 0, "R12 ready low after accept", req_ready, 0);
    rd = '0;
    if (!wr) begin
      while (!rd_valid) tick();
      rd = rd_data;
    end
    wait_idle();
    chk(ras_n == 1 && hi_cnt >= T_RP, "R12 ready back after precharge", hi_cnt, T_RP);
    chk(cur_row == row[ROW_W-1:0], "R2 row latched at row strobe", cur_row, row);
    chk(cur_col == col[COL_W-1:0], "R2 column latched at column strobe", cur_col, col);
  endtask

  task automatic t_reset();
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid, "R1 driver off, no read valid", {dq_oe, rd_valid}, 0);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
  endtask

  task automatic t_ror_spacing();
    int n, r0;
    ref_cbr = 0;
    n = ref_cnt;
    while (ref_cnt < n + 3) tick();
    chk(ref_t_last - ref_t_prev == REF_PER, "R10 idle refresh spacing", ref_t_last - ref_t_prev, REF_PER);
    r0 = prev_ror_row;
    chk(last_ror_row == ROW_W'(r0 + 1), "R8 row counter advances", last_ror_row, r0 + 1);
    n = ror_cnt;
    while (ror_cnt == n) tick();
    chk(last_ror_row == ROW_W'(r0 + 2), "R8 row counter sequence", last_ror_row, r0 + 2);
  endtask

  task automatic t_rw();
    logic [7:0] rd;
    access(1, 0, 0, 8'h00, rd);
    access(1, 63, 31, 8'hFF, rd);
    access(1, 5, 10, 8'hA5, rd);
    access(1, 42, 21, 8'h5A, rd);
    access(0, 63, 31, 8'h00, rd);
    chk(rd == 8'hFF, "R3 read top row/col", rd, 8'hFF);
    access(0, 0, 0, 8'h00, rd);
    chk(rd == 8'h00, "R3 read zero location", rd, 0);
    access(0, 42, 21, 8'h00, rd);
    chk(rd == 8'h5A, "R3 read alternating 5A", rd, 8'h5A);
    access(1, 5, 10, 8'h3C, rd);
    access(0, 5, 10, 8'h00, rd);
    chk(rd == 8'h3C, "R3 overwrite then read", rd, 8'h3C);
  endtask

  task automatic t_priority();
    logic [7:0] rd;
    int n, t0;
    n = ref_cnt;
    while (ref_cnt < n + 2) tick();
    t0 = ref_t_last;
    while (cyc != t0 + REF_PER - 2) tick();
    chk(req_ready == 0, "R11 ready low while refresh pending", req_ready, 0);
    n = ref_cnt;
    access(0, 5, 10, 8'h00, rd);
    chk(ref_cnt == n + 1, "R11 refresh ran before request", ref_cnt, n + 1);
    chk(ref_t_last == t0 + REF_PER, "R11 refresh not deferred", ref_t_last, t0 + REF_PER);
    chk(rd == 8'h3C, "R11 request served after refresh", rd, 8'h3C);
  endtask

  task automatic t_cbr();
    int nc, nr, rrow;
    rrow = last_ror_row;
    ref_cbr = 1;
    nc = cbr_cnt; nr = ror_cnt;
    while (cbr_cnt < nc + 2) tick();
    chk(ror_cnt == nr, "R9 no row-strobe-only refresh in column-first mode", ror_cnt, nr);
    chk(cbr_order_err == 0, "R9 column strobe leads row strobe", cbr_order_err, 0);
    wait_idle();
    ref_cbr = 0;
    while (ror_cnt == nr) tick();
    chk(last_ror_row == ROW_W'(rrow + 1), "R9 row counter held during column-first refresh", last_ror_row, rrow + 1);
  endtask

  task automatic t_timing();
    chk(bus_err == 0, "R4 driver off while memory drives", bus_err, 0);
    chk(rcd_err == 0, "R5 row-to-column delay", rcd_err, 0);
    chk(ras_err == 0, "R6 row strobe active time", ras_err, 0);
    chk(rp_err == 0, "R7 precharge time", rp_err, 0);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_rw();
    t_ror_spacing();
    t_priority();
    t_cbr();
    t_rw();
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule